// File: doc/BRIEF.md
# Multi-Source IQ Parallel Output Port

This block gathers complex results from up to four filter channels, or alternatively from two gain-control stages, and sends them out one result at a time on a 16-bit parallel bus. Each source pulses a one-cycle strobe when a new I/Q pair is on its data pins. The block captures the pair and queues the source's index, so results leave in the order their strobes arrived.

A static configuration chooses which set of sources is served, which sources in that set are enabled, and the word format. In interleaved format each result takes two bus words: I first, then Q. In packed format each result is one word that carries the upper halves of both samples. A source indicator names the origin of the word on the bus, and an IQ flag tells I words from Q words.

The output is a valid/ready stream. A word stays on the bus, unchanged, until it is accepted: the cycle in which `out_valid` and `out_ready` are both high. The source side has no back-pressure. Every enabled strobe is taken, and a repeated strobe from a source that is still waiting replaces that source's stored sample.

Top module: `iq_par_port`

## Requirements
- R1: After reset, `out_valid` is low and stays low until an enabled source strobes.
- R2: When `cfg_src_gain` is 0, channel k (k = 0..3) is served when `cfg_en[k]` is 1. Its words carry `out_src` = k.
- R3: When `cfg_src_gain` is 1, gain stage A is index 0 and gain stage B is index 1. They are enabled by `cfg_en[0]` and `cfg_en[1]`. Channel strobes produce no output, and `out_src` is 0 or 1.
- R4: A strobe from a source whose enable bit is 0 produces no output word.
- R5: Results leave in the order their strobes arrived. Strobes that arrive in the same cycle leave lowest index first.
- R6: With `cfg_packed` = 0, each result is two words from the same source. The I word comes first with `out_iq` = 1, and the Q word follows with `out_iq` = 0. No other source's word comes between them.
- R7: With `cfg_packed` = 1, each result is one word {I[15:8], Q[15:8]}, with I in bits 15:8, Q in bits 7:0, and `out_iq` = 1.
- R8: A strobe from a source that is already waiting and has not yet begun output does not add a second result. The single result that leaves carries the newest sample.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_iq` and `out_src` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_gain | input | 1 | 0: serve channels, 1: serve gain stages |
| cfg_en | input | 4 | Per-source enable, bit k for index k |
| cfg_packed | input | 1 | 0: interleaved I/Q words, 1: packed 8+8 word |
| ch_stb | input | 4 | New-result strobe per channel |
| ch_i | input | 64 | Channel I samples, channel k at bits 16k+15:16k |
| ch_q | input | 64 | Channel Q samples, same layout |
| gc_stb | input | 2 | New-result strobe per gain stage (bit 0 = A) |
| gc_i | input | 32 | Gain-stage I samples, stage k at bits 16k+15:16k |
| gc_q | input | 32 | Gain-stage Q samples, same layout |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Sink accepts the word this cycle |
| out_data | output | 16 | Output word |
| out_iq | output | 1 | 1 for an I word or packed word, 0 for a Q word |
| out_src | output | 2 | Index of the source of the current word |

## Verification
The assertions assume that `cfg_src_gain`, `cfg_en` and `cfg_packed` change only while the block is idle: nothing queued and nothing on the bus. Under that assumption, a word's source index always names an enabled source, and the format flag describes the word currently shown. The bench changes configuration only at the start of a scenario, after the previous traffic has drained. It holds `out_ready` low only inside the back-pressure scenario.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;

  typedef enum logic {
    SET_CHANNEL = 1'b0,
    SET_GAIN    = 1'b1
  } src_set_e;

  // Upper half of a sample, used to build one packed I/Q word.
  function automatic logic [7:0] upper_byte(input logic [15:0] s);
    return s[15:8];
  endfunction

endpackage

// File: rtl/iq_src_select.sv
module iq_src_select #(
  parameter int N_CH = 4,
  parameter int N_GC = 2,
  parameter int SW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_src_gain,
  input  logic [N_CH-1:0]    cfg_en,
  input  logic [N_CH-1:0]    ch_stb,
  input  logic [N_CH*SW-1:0] ch_i,
  input  logic [N_CH*SW-1:0] ch_q,
  input  logic [N_GC-1:0]    gc_stb,
  input  logic [N_GC*SW-1:0] gc_i,
  input  logic [N_GC*SW-1:0] gc_q,
  output logic [N_CH-1:0]    req,
  output logic [N_CH*SW-1:0] hold_i,
  output logic [N_CH*SW-1:0] hold_q
);
  import iq_port_pkg::*;

  logic use_gain;
  assign use_gain = (src_set_e'(cfg_src_gain) == SET_GAIN);

  for (genvar k = 0; k < N_CH; k++) begin : g_src
    logic          stb_k;
    logic [SW-1:0] i_k, q_k;
    if (k < N_GC) begin : g_shared
      assign stb_k = use_gain ? gc_stb[k]         : ch_stb[k];
      assign i_k   = use_gain ? gc_i[k*SW +: SW] : ch_i[k*SW +: SW];
      assign q_k   = use_gain ? gc_q[k*SW +: SW] : ch_q[k*SW +: SW];
    end else begin : g_chan_only
      assign stb_k = use_gain ? 1'b0 : ch_stb[k];
      assign i_k   = ch_i[k*SW +: SW];
      assign q_k   = ch_q[k*SW +: SW];
    end

    assign req[k] = stb_k & cfg_en[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_i[k*SW +: SW] <= '0;
        hold_q[k*SW +: SW] <= '0;
      end else if (req[k]) begin
        hold_i[k*SW +: SW] <= i_k;
        hold_q[k*SW +: SW] <= q_k;
      end
    end
  end

endmodule

// File: rtl/iq_order_fifo.sv
module iq_order_fifo #(
  parameter int N     = 4,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 pop,
  output logic                 empty,
  output logic [$clog2(N)-1:0] head
);
  localparam int IW = $clog2(N);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] q   [DEPTH];
  logic [IW-1:0] q_n [DEPTH];
  logic [N-1:0]  pend, pend_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    q_n    = q;
    pend_n = pend;
    cnt_n  = cnt;
    if (pop) begin
      pend_n[q[0]] = 1'b0;
      for (int d = 0; d < DEPTH - 1; d++) q_n[d] = q[d+1];
      q_n[DEPTH-1] = '0;
      cnt_n = cnt - 1'b1;
    end
    // Lower indices are appended first when strobes coincide.
    for (int k = 0; k < N; k++) begin
      if (req[k] && !pend_n[k] && (cnt_n < CW'(DEPTH))) begin
        q_n[cnt_n[AW-1:0]] = IW'(k);
        pend_n[k]          = 1'b1;
        cnt_n              = cnt_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      cnt  <= '0;
      for (int d = 0; d < DEPTH; d++) q[d] <= '0;
    end else begin
      pend <= pend_n;
      cnt  <= cnt_n;
      for (int d = 0; d < DEPTH; d++) q[d] <= q_n[d];
    end
  end

  assign empty = (cnt == '0);
  assign head  = q[0];

endmodule

// File: rtl/iq_word_fmt.sv
module iq_word_fmt #(
  parameter int SW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_packed,
  input  logic          fifo_empty,
  input  logic [IW-1:0] head_idx,
  input  logic [SW-1:0] head_i,
  input  logic [SW-1:0] head_q,
  output logic          pop,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [SW-1:0] out_data,
  output logic          out_iq,
  output logic [IW-1:0] out_src
);
  import iq_port_pkg::*;

  localparam int H = SW / 2;

  logic          last_w;
  logic [SW-1:0] q_save;
  logic          accept;

  assign accept = out_valid && out_ready;
  assign pop    = !fifo_empty && (!out_valid || (out_ready && last_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_iq    <= 1'b0;
      out_src   <= '0;
      last_w    <= 1'b0;
      q_save    <= '0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_src   <= head_idx;
      out_iq    <= 1'b1;
      if (cfg_packed) begin
        out_data <= {head_i[SW-1 -: H], head_q[SW-1 -: H]};
        last_w   <= 1'b1;
      end else begin
        out_data <= head_i;
        q_save   <= head_q;
        last_w   <= 1'b0;
      end
    end else if (accept) begin
      if (!last_w) begin
        out_data <= q_save;
        out_iq   <= 1'b0;
        last_w   <= 1'b1;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/iq_par_port.sv
module iq_par_port #(
  parameter int N_CH  = 4,
  parameter int N_GC  = 2,
  parameter int SW    = 16,
  parameter int DEPTH = N_CH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_src_gain,
  input  logic [N_CH-1:0]          cfg_en,
  input  logic                     cfg_packed,
  input  logic [N_CH-1:0]          ch_stb,
  input  logic [N_CH*SW-1:0]       ch_i,
  input  logic [N_CH*SW-1:0]       ch_q,
  input  logic [N_GC-1:0]          gc_stb,
  input  logic [N_GC*SW-1:0]       gc_i,
  input  logic [N_GC*SW-1:0]       gc_q,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [SW-1:0]            out_data,
  output logic                     out_iq,
  output logic [$clog2(N_CH)-1:0]  out_src
);
  localparam int IW = $clog2(N_CH);

  logic [N_CH-1:0]    req;
  logic [N_CH*SW-1:0] hold_i, hold_q;
  logic               fifo_empty, pop;
  logic [IW-1:0]      head;
  logic [SW-1:0]      head_i, head_q;

  iq_src_select #(.N_CH(N_CH), .N_GC(N_GC), .SW(SW)) u_sel (
    .clk(clk), .rst_n(rst_n), .cfg_src_gain(cfg_src_gain), .cfg_en(cfg_en),
    .ch_stb(ch_stb), .ch_i(ch_i), .ch_q(ch_q),
    .gc_stb(gc_stb), .gc_i(gc_i), .gc_q(gc_q),
    .req(req), .hold_i(hold_i), .hold_q(hold_q)
  );

  iq_order_fifo #(.N(N_CH), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .req(req), .pop(pop),
    .empty(fifo_empty), .head(head)
  );

  assign head_i = hold_i[head*SW +: SW];
  assign head_q = hold_q[head*SW +: SW];

  iq_word_fmt #(.SW(SW), .IW(IW)) u_fmt (
    .clk(clk), .rst_n(rst_n), .cfg_packed(cfg_packed),
    .fifo_empty(fifo_empty), .head_idx(head), .head_i(head_i), .head_q(head_q),
    .pop(pop), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_iq(out_iq), .out_src(out_src)
  );

endmodule

// File: rtl/iq_par_port_chk.sv
module iq_par_port_chk #(
  parameter int N_CH = 4,
  parameter int SW   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_src_gain,
  input logic [N_CH-1:0]         cfg_en,
  input logic                    cfg_packed,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [SW-1:0]           out_data,
  input logic                    out_iq,
  input logic [$clog2(N_CH)-1:0] out_src
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_iq) && $stable(out_src)); // R9

  AST_Q_FOLLOWS_I: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_iq && !cfg_packed |=> out_valid && !out_iq && $stable(out_src)); // R6

  AST_PACKED_IQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_packed |-> out_iq); // R7

  AST_GAIN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_src_gain |-> out_src < 2); // R3

  AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cfg_en[out_src]); // R4

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1

endmodule

bind iq_par_port iq_par_port_chk #(.N_CH(N_CH), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_src_gain(cfg_src_gain), .cfg_en(cfg_en),
  .cfg_packed(cfg_packed), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_iq(out_iq), .out_src(out_src)
);

// File: tb/iq_par_port_tb_top.sv
module iq_par_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_src_gain = 1'b0;
  logic [3:0]  cfg_en = 4'hF;
  logic        cfg_packed = 1'b0;
  logic [3:0]  ch_stb = '0;
  logic [63:0] ch_i = '0, ch_q = '0;
  logic [1:0]  gc_stb = '0;
  logic [31:0] gc_i = '0, gc_q = '0;
  logic        out_valid, out_iq;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [1:0]  out_src;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] cap_d [64];
  logic        cap_iq [64];
  logic [1:0]  cap_src [64];
  int ncap = 0;

  always #4 clk = ~clk;

  iq_par_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_src_gain(cfg_src_gain), .cfg_en(cfg_en),
    .cfg_packed(cfg_packed), .ch_stb(ch_stb), .ch_i(ch_i), .ch_q(ch_q),
    .gc_stb(gc_stb), .gc_i(gc_i), .gc_q(gc_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_iq(out_iq), .out_src(out_src)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 64) begin
      cap_d[ncap] = out_data; cap_iq[ncap] = out_iq; cap_src[ncap] = out_src;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_word(input int idx, input int src, input bit iq,
                            input logic [15:0] d, input string tag);
    if (idx >= ncap) begin
      chk(0, {tag, " missing word"}, ncap, idx + 1);
    end else begin
      chk(cap_src[idx] == 2'(src), {tag, " src"}, cap_src[idx], src);
      chk(cap_iq[idx] == iq, {tag, " iq"}, cap_iq[idx], iq);
      chk(cap_d[idx] == d, {tag, " data"}, cap_d[idx], d);
    end
  endtask

  task automatic set_ch(input int k, input logic [15:0] i, input logic [15:0] q);
    ch_i[k*16 +: 16] = i; ch_q[k*16 +: 16] = q;
  endtask

  task automatic pulse(input logic [3:0] c, input logic [1:0] g);
    ch_stb = c; gc_stb = g;
    @(negedge clk);
    ch_stb = '0; gc_stb = '0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);
  endtask

  task automatic t_order_interleaved();
    ncap = 0; cfg_src_gain = 0; cfg_en = 4'hF; cfg_packed = 0;
    set_ch(2, 16'h2A2A, 16'h2B2B); pulse(4'b0100, 2'b00);
    set_ch(0, 16'h0A0A, 16'h0B0B); pulse(4'b0001, 2'b00);
    settle();
    chk(ncap == 4, "R5 word count", ncap, 4);
    check_word(0, 2, 1, 16'h2A2A, "R2 R6 first I");
    check_word(1, 2, 0, 16'h2B2B, "R6 first Q");
    check_word(2, 0, 1, 16'h0A0A, "R5 second I");
    check_word(3, 0, 0, 16'h0B0B, "R6 second Q");
  endtask

  task automatic t_same_cycle();
    ncap = 0;
    set_ch(3, 16'h3333, 16'h3434); set_ch(1, 16'h1111, 16'h1212);
    pulse(4'b1010, 2'b00);
    settle();
    chk(ncap == 4, "R5 tie count", ncap, 4);
    check_word(0, 1, 1, 16'h1111, "R5 tie low first");
    check_word(2, 3, 1, 16'h3333, "R5 tie high second");
  endtask

  task automatic t_disabled();
    ncap = 0; cfg_en = 4'b0101;
    set_ch(0, 16'hC0C0, 16'hC1C1); set_ch(1, 16'hD0D0, 16'hD1D1);
    pulse(4'b0011, 2'b00);
    settle();
    chk(ncap == 2, "R4 disabled source dropped", ncap, 2);
    check_word(0, 0, 1, 16'hC0C0, "R4 enabled source");
    cfg_en = 4'hF;
  endtask

  task automatic t_packed();
    ncap = 0; cfg_packed = 1;
    set_ch(0, 16'hABCD, 16'h1234); pulse(4'b0001, 2'b00);
    settle();
    chk(ncap == 1, "R7 one word", ncap, 1);
    check_word(0, 0, 1, 16'hAB12, "R7 packed");
    cfg_packed = 0;
  endtask

  task automatic t_gain();
    ncap = 0; cfg_src_gain = 1; cfg_en = 4'b0011;
    gc_i[31:16] = 16'h5A5A; gc_q[31:16] = 16'hA5A5;
    set_ch(1, 16'hEEEE, 16'hEEEF);
    pulse(4'b1111, 2'b10);
    settle();
    chk(ncap == 2, "R3 channels ignored", ncap, 2);
    check_word(0, 1, 1, 16'h5A5A, "R3 gain B I");
    check_word(1, 1, 0, 16'hA5A5, "R3 gain B Q");
    cfg_src_gain = 0; cfg_en = 4'hF;
  endtask

  task automatic t_stall_merge();
    ncap = 0; out_ready = 0;
    set_ch(1, 16'h1111, 16'h1112); pulse(4'b0010, 2'b00);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid under stall", out_valid, 1);
    chk(out_data == 16'h1111, "R9 data held", out_data, 16'h1111);
    set_ch(2, 16'h2221, 16'h2222); pulse(4'b0100, 2'b00);
    set_ch(2, 16'h2231, 16'h2232); pulse(4'b0100, 2'b00);
    set_ch(3, 16'h3331, 16'h3332); pulse(4'b1000, 2'b00);
    repeat (3) @(negedge clk);
    chk(out_data == 16'h1111 && out_iq, "R9 still held", out_data, 16'h1111);
    out_ready = 1;
    settle();
    chk(ncap == 6, "R8 merged count", ncap, 6);
    check_word(1, 1, 0, 16'h1112, "R9 Q after stall");
    check_word(2, 2, 1, 16'h2231, "R8 newest I");
    check_word(3, 2, 0, 16'h2232, "R8 newest Q");
    check_word(4, 3, 1, 16'h3331, "R8 next source");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order_interleaved();
    t_same_cycle();
    t_disabled();
    t_packed();
    t_gain();
    t_stall_merge();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule